// File: doc/BRIEF.md
# Integer Execute Unit with Condition Bit

This block is the integer execute stage of a small RISC core. Each cycle it can accept one operation: two register operands, a 16-bit immediate field, a 4-bit operation code and the core's current condition bit. One clock later it presents a 32-bit result, a register write-enable and the value the condition bit should take next. The operations are additions (plain, with a sign-extended 16-bit or 8-bit immediate, with signed-overflow detection and with carry-in), AND with a zero-extended immediate, signed and unsigned less-than compares in register and immediate forms, a single-bit test and a clear of selected bits in the low byte of a status word.

The condition bit does not have one fixed meaning. For each operation it is either left alone or loaded with that operation's own outcome: signed overflow, carry out, compare result, the tested bit, or bit 0 of the new status word. Bit-test positions count from the top of a byte, so position 0 names bit 7. The surrounding core feeds `cond_out` back into `cond_in`.

Top module: `alu_exec`

## Requirements
- R1: While `rst_n` is low, and on the first sample after it is asserted, `out_valid`, `wr_en`, `result` and `cond_out` are all 0.
- R2: `out_valid` equals the previous cycle's `in_valid`. Every output reflects the operation accepted on the previous rising edge.
- R3: Opcodes 0 (A+B), 1 (A + sign-extended imm[15:0]) and 2 (A + sign-extended imm[7:0], with imm[15:8] ignored) write the 32-bit sum and set `wr_en`. `cond_out` equals `cond_in`.
- R4: Opcodes 3 (A+B) and 4 (A + sign-extended imm[15:0]) write the sum, set `wr_en`, and set `cond_out` to the signed two's-complement overflow of the addition.
- R5: Opcode 5 writes A+B+`cond_in`, sets `wr_en`, and sets `cond_out` to the carry out of bit 31.
- R6: Opcode 6 writes A AND zero-extended imm[15:0], sets `wr_en`, and leaves `cond_out` equal to `cond_in`.
- R7: Opcodes 7 (register) and 8 (sign-extended imm[15:0]) set `cond_out` to signed A < signed B. `wr_en` is 0 and `result` is 0.
- R8: Opcodes 9 (register) and 10 (imm[15:0] sign-extended, then treated as unsigned) set `cond_out` to unsigned A < B. `wr_en` is 0 and `result` is 0.
- R9: Opcode 11 sets `cond_out` to A[7 − imm[2:0]], so imm[2:0]=0 selects bit 7. `wr_en` is 0 and `result` is 0.
- R10: Opcode 12 writes A with the bits set in imm[7:0] cleared in bits 7..0, keeps A[31:8] unchanged, sets `wr_en`, and sets `cond_out` to bit 0 of the new value.
- R11: Opcodes 13 to 15 give `wr_en` 0 and `result` 0, and leave `cond_out` equal to `cond_in`.
- R12: In a cycle after `in_valid` was low, `out_valid` and `wr_en` are 0 and `cond_out` equals the previous `cond_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | An operation is presented this cycle |
| op | input | 4 | Operation code, values as in the requirements |
| src_a | input | 32 | First register operand, or status word for opcode 12 |
| src_b | input | 32 | Second register operand |
| imm | input | 16 | Immediate field, bit position or clear mask |
| cond_in | input | 1 | Current condition bit |
| out_valid | output | 1 | Registered outputs belong to an accepted operation |
| result | output | 32 | Value to write to the destination register |
| wr_en | output | 1 | Destination register write-enable |
| cond_out | output | 1 | Next value of the condition bit |

## Verification
The hardest cases to reach are the ones where the condition bit's new value depends on a boundary of the arithmetic rather than on the opcode alone. Signed overflow needs same-sign operands whose sum crosses 0x7FFFFFFF or 0x80000000. Carry out needs a carry-in that ripples through an all-ones operand. The unsigned immediate compare only differs from a zero-extending compare when imm bit 15 is set. The vector table places operands exactly at those edges, and sets `cond_in` opposite to the expected `cond_out` wherever the bit should change, so a stale or passed-through condition bit is detected. It also repeats the bit test at both ends of the byte and with imm bits above [2:0] set.

// File: rtl/alu_pkg.sv
package alu_pkg;

   localparam int OP_W = 4;

   typedef enum logic [OP_W-1:0] {
      OP_ADD      = 4'd0,
      OP_ADD_I16  = 4'd1,
      OP_ADD_I8   = 4'd2,
      OP_ADDV     = 4'd3,
      OP_ADDV_I16 = 4'd4,
      OP_ADDC     = 4'd5,
      OP_AND_I16  = 4'd6,
      OP_SLT      = 4'd7,
      OP_SLT_I    = 4'd8,
      OP_SLTU     = 4'd9,
      OP_SLTU_I   = 4'd10,
      OP_BTST     = 4'd11,
      OP_CLRST    = 4'd12
   } alu_op_e;

endpackage

// File: rtl/alu_adder.sv
module alu_adder #(
   parameter int W      = 32,
   parameter bit RIPPLE = 1'b0
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic         cin,
   output logic [W-1:0] sum,
   output logic         cout,
   output logic         ovf
);

   generate
      if (RIPPLE) begin : g_ripple
         logic [W:0] carry;
         assign carry[0] = cin;
         for (genvar i = 0; i < W; i++) begin : g_bit
            assign sum[i]     = a[i] ^ b[i] ^ carry[i];
            assign carry[i+1] = (a[i] & b[i]) | (carry[i] & (a[i] ^ b[i]));
         end
         assign cout = carry[W];
         assign ovf  = carry[W] ^ carry[W-1];
      end else begin : g_behav
         logic [W:0] wide;
         assign wide = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
         assign sum  = wide[W-1:0];
         assign cout = wide[W];
         assign ovf  = (a[W-1] == b[W-1]) && (wide[W-1] != a[W-1]);
      end
   endgenerate

endmodule

// File: rtl/alu_compare.sv
module alu_compare #(
   parameter int W = 32
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic         is_signed,
   output logic         lt
);

   logic lt_s;
   logic lt_u;

   assign lt_s = $signed(a) < $signed(b);
   assign lt_u = a < b;
   assign lt   = is_signed ? lt_s : lt_u;

endmodule

// File: rtl/alu_bitops.sv
module alu_bitops #(
   parameter int W        = 32,
   parameter int BYTE_W   = 8,
   parameter int COND_POS = 0,
   localparam int BPOS_W  = $clog2(BYTE_W)
) (
   input  logic [W-1:0]      a,
   input  logic [W-1:0]      zimm,
   input  logic [BYTE_W-1:0] mask,
   input  logic [BPOS_W-1:0] bitpos,
   output logic [W-1:0]      and_res,
   output logic [W-1:0]      clr_res,
   output logic              clr_cond,
   output logic              test_bit
);

   logic [BYTE_W-1:0] low_byte;
   logic [BPOS_W-1:0] rev_pos;

   assign and_res  = a & zimm;
   assign low_byte = a[BYTE_W-1:0] & ~mask;
   assign clr_res  = {a[W-1:BYTE_W], low_byte};
   assign clr_cond = low_byte[COND_POS];
   assign rev_pos  = BPOS_W'(BYTE_W - 1) - bitpos;
   assign test_bit = a[rev_pos];

endmodule

// File: rtl/alu_exec.sv
module alu_exec
   import alu_pkg::*;
#(
   parameter int DATA_W   = 32,
   parameter int IMM_W    = 16,
   parameter int SIMM_W   = 8,
   parameter int BYTE_W   = 8,
   parameter int COND_POS = 0,
   parameter bit RIPPLE   = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [OP_W-1:0]   op,
   input  logic [DATA_W-1:0] src_a,
   input  logic [DATA_W-1:0] src_b,
   input  logic [IMM_W-1:0]  imm,
   input  logic              cond_in,
   output logic              out_valid,
   output logic [DATA_W-1:0] result,
   output logic              wr_en,
   output logic              cond_out
);

   localparam int BPOS_W = $clog2(BYTE_W);

   generate
      if (DATA_W <= IMM_W) begin : g_bad_data_w
         $error("DATA_W must exceed IMM_W");
      end
      if (SIMM_W > IMM_W || SIMM_W > BYTE_W) begin : g_bad_simm_w
         $error("SIMM_W must fit inside IMM_W and BYTE_W");
      end
      if ((1 << BPOS_W) != BYTE_W || BYTE_W > IMM_W) begin : g_bad_byte_w
         $error("BYTE_W must be a power of two not above IMM_W");
      end
      if (COND_POS >= BYTE_W) begin : g_bad_cond_pos
         $error("COND_POS must lie in the low byte");
      end
   endgenerate

   // immediate forms
   logic [DATA_W-1:0] imm_sx16;
   logic [DATA_W-1:0] imm_sx8;
   logic [DATA_W-1:0] imm_zx16;

   assign imm_sx16 = {{(DATA_W-IMM_W){imm[IMM_W-1]}}, imm};
   assign imm_sx8  = {{(DATA_W-SIMM_W){imm[SIMM_W-1]}}, imm[SIMM_W-1:0]};
   assign imm_zx16 = {{(DATA_W-IMM_W){1'b0}}, imm};

   // adder operand selection
   logic [DATA_W-1:0] add_b;
   logic              add_cin;
   logic [DATA_W-1:0] add_sum;
   logic              add_cout;
   logic              add_ovf;

   always_comb begin
      case (op)
         OP_ADD_I16, OP_ADDV_I16: add_b = imm_sx16;
         OP_ADD_I8:               add_b = imm_sx8;
         default:                 add_b = src_b;
      endcase
      add_cin = (op == OP_ADDC) ? cond_in : 1'b0;
   end

   alu_adder #(
      .W      (DATA_W),
      .RIPPLE (RIPPLE)
   ) u_adder (
      .a    (src_a),
      .b    (add_b),
      .cin  (add_cin),
      .sum  (add_sum),
      .cout (add_cout),
      .ovf  (add_ovf)
   );

   // compare unit
   logic [DATA_W-1:0] cmp_b;
   logic              cmp_signed;
   logic              cmp_lt;

   assign cmp_b      = (op == OP_SLT_I || op == OP_SLTU_I) ? imm_sx16 : src_b;
   assign cmp_signed = (op == OP_SLT || op == OP_SLT_I);

   alu_compare #(
      .W (DATA_W)
   ) u_cmp (
      .a         (src_a),
      .b         (cmp_b),
      .is_signed (cmp_signed),
      .lt        (cmp_lt)
   );

   // logic and bit unit
   logic [DATA_W-1:0] and_res;
   logic [DATA_W-1:0] clr_res;
   logic              clr_cond;
   logic              test_bit;

   alu_bitops #(
      .W        (DATA_W),
      .BYTE_W   (BYTE_W),
      .COND_POS (COND_POS)
   ) u_bits (
      .a        (src_a),
      .zimm     (imm_zx16),
      .mask     (imm[BYTE_W-1:0]),
      .bitpos   (imm[BPOS_W-1:0]),
      .and_res  (and_res),
      .clr_res  (clr_res),
      .clr_cond (clr_cond),
      .test_bit (test_bit)
   );

   // result and condition selection
   logic [DATA_W-1:0] nxt_res;
   logic              nxt_we;
   logic              nxt_cond;

   always_comb begin
      nxt_res  = '0;
      nxt_we   = 1'b0;
      nxt_cond = cond_in;
      case (op)
         OP_ADD, OP_ADD_I16, OP_ADD_I8: begin
            nxt_res = add_sum;
            nxt_we  = 1'b1;
         end
         OP_ADDV, OP_ADDV_I16: begin
            nxt_res  = add_sum;
            nxt_we   = 1'b1;
            nxt_cond = add_ovf;
         end
         OP_ADDC: begin
            nxt_res  = add_sum;
            nxt_we   = 1'b1;
            nxt_cond = add_cout;
         end
         OP_AND_I16: begin
            nxt_res = and_res;
            nxt_we  = 1'b1;
         end
         OP_SLT, OP_SLT_I, OP_SLTU, OP_SLTU_I: begin
            nxt_cond = cmp_lt;
         end
         OP_BTST: begin
            nxt_cond = test_bit;
         end
         OP_CLRST: begin
            nxt_res  = clr_res;
            nxt_we   = 1'b1;
            nxt_cond = clr_cond;
         end
         default: begin
            nxt_res  = '0;
            nxt_we   = 1'b0;
            nxt_cond = cond_in;
         end
      endcase
   end

   // output stage
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         result    <= '0;
         wr_en     <= 1'b0;
         cond_out  <= 1'b0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            result   <= nxt_res;
            wr_en    <= nxt_we;
            cond_out <= nxt_cond;
         end else begin
            wr_en    <= 1'b0;
            cond_out <= cond_in;
         end
      end
   end

endmodule

// File: rtl/alu_exec_chk.sv
module alu_exec_chk
   import alu_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int IMM_W  = 16,
   parameter int BYTE_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic [OP_W-1:0]   op,
   input logic [DATA_W-1:0] src_a,
   input logic [DATA_W-1:0] src_b,
   input logic [IMM_W-1:0]  imm,
   input logic              cond_in,
   input logic              out_valid,
   input logic [DATA_W-1:0] result,
   input logic              wr_en,
   input logic              cond_out
);

   localparam int BPOS_W = $clog2(BYTE_W);

   logic is_cmp;
   logic is_plain;
   logic is_undef;
   logic [DATA_W-1:0] sum_rr;

   assign is_cmp   = op == OP_SLT || op == OP_SLT_I || op == OP_SLTU || op == OP_SLTU_I
                     || op == OP_BTST;
   assign is_plain = op == OP_ADD || op == OP_ADD_I16 || op == OP_ADD_I8 || op == OP_AND_I16;
   assign is_undef = op > OP_CLRST;
   assign sum_rr   = src_a + src_b;

   assert_reset_R1: assert property (@(posedge clk)
      !rst_n |=> (!out_valid && !wr_en && result == '0 && !cond_out));

   assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);

   assert_plain_cond_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && is_plain) |=> (cond_out == $past(cond_in) && wr_en));

   assert_add_sum_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op == OP_ADD) |=> result == $past(sum_rr));

   assert_no_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && is_cmp) |=> (!wr_en && result == '0));

   assert_bit_test_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op == OP_BTST)
      |=> cond_out == $past(src_a[BYTE_W-1-int'(imm[BPOS_W-1:0])]));

   assert_clear_upper_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op == OP_CLRST)
      |=> (result[DATA_W-1:BYTE_W] == $past(src_a[DATA_W-1:BYTE_W]) && wr_en));

   assert_undef_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && is_undef) |=> (!wr_en && cond_out == $past(cond_in)));

   assert_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> (!out_valid && !wr_en && cond_out == $past(cond_in)));

endmodule

bind alu_exec alu_exec_chk #(
   .DATA_W (DATA_W),
   .IMM_W  (IMM_W),
   .BYTE_W (BYTE_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .op        (op),
   .src_a     (src_a),
   .src_b     (src_b),
   .imm       (imm),
   .cond_in   (cond_in),
   .out_valid (out_valid),
   .result    (result),
   .wr_en     (wr_en),
   .cond_out  (cond_out)
);

// File: tb/alu_exec_tb.sv
module alu_exec_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [3:0]  op = '0;
   logic [31:0] src_a = '0;
   logic [31:0] src_b = '0;
   logic [15:0] imm = '0;
   logic        cond_in = 1'b0;
   logic        out_valid;
   logic [31:0] result;
   logic        wr_en;
   logic        cond_out;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   alu_exec u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .op        (op),
      .src_a     (src_a),
      .src_b     (src_b),
      .imm       (imm),
      .cond_in   (cond_in),
      .out_valid (out_valid),
      .result    (result),
      .wr_en     (wr_en),
      .cond_out  (cond_out)
   );

   typedef struct packed {
      logic [3:0]  op;
      logic [31:0] a;
      logic [31:0] b;
      logic [15:0] imm;
      logic        cin;
      logic [31:0] res;
      logic        we;
      logic        c;
   } vec_t;

   localparam int NV = 21;
   localparam vec_t VECS [NV] = '{
      '{4'd0,  32'h0000_0005, 32'h0000_0003, 16'h0000, 1'b1, 32'h0000_0008, 1'b1, 1'b1}, // R3
      '{4'd1,  32'h0000_0010, 32'h0000_0000, 16'hFFFF, 1'b0, 32'h0000_000F, 1'b1, 1'b0}, // R3
      '{4'd2,  32'h0000_0100, 32'h0000_0000, 16'hAB80, 1'b1, 32'h0000_0080, 1'b1, 1'b1}, // R3
      '{4'd3,  32'h7FFF_FFFF, 32'h0000_0001, 16'h0000, 1'b0, 32'h8000_0000, 1'b1, 1'b1}, // R4
      '{4'd3,  32'h0000_0005, 32'hFFFF_FFFF, 16'h0000, 1'b1, 32'h0000_0004, 1'b1, 1'b0}, // R4
      '{4'd4,  32'h8000_0000, 32'h0000_0000, 16'hFFFF, 1'b0, 32'h7FFF_FFFF, 1'b1, 1'b1}, // R4
      '{4'd5,  32'hFFFF_FFFF, 32'h0000_0000, 16'h0000, 1'b1, 32'h0000_0000, 1'b1, 1'b1}, // R5
      '{4'd5,  32'h0000_0002, 32'h0000_0003, 16'h0000, 1'b0, 32'h0000_0005, 1'b1, 1'b0}, // R5
      '{4'd6,  32'hFFFF_1234, 32'h0000_0000, 16'hF0F0, 1'b1, 32'h0000_1030, 1'b1, 1'b1}, // R6
      '{4'd7,  32'hFFFF_FFFF, 32'h0000_0001, 16'h0000, 1'b0, 32'h0000_0000, 1'b0, 1'b1}, // R7
      '{4'd7,  32'h0000_0001, 32'hFFFF_FFFF, 16'h0000, 1'b1, 32'h0000_0000, 1'b0, 1'b0}, // R7
      '{4'd8,  32'hFFFF_FFFE, 32'h0000_0000, 16'hFFFF, 1'b0, 32'h0000_0000, 1'b0, 1'b1}, // R7
      '{4'd9,  32'hFFFF_FFFF, 32'h0000_0001, 16'h0000, 1'b1, 32'h0000_0000, 1'b0, 1'b0}, // R8
      '{4'd10, 32'h0001_0000, 32'h0000_0000, 16'h8000, 1'b0, 32'h0000_0000, 1'b0, 1'b1}, // R8
      '{4'd11, 32'h0000_0080, 32'h0000_0000, 16'h0000, 1'b0, 32'h0000_0000, 1'b0, 1'b1}, // R9
      '{4'd11, 32'h0000_0080, 32'h0000_0000, 16'h0007, 1'b1, 32'h0000_0000, 1'b0, 1'b0}, // R9
      '{4'd11, 32'h0000_0001, 32'h0000_0000, 16'hFFFF, 1'b0, 32'h0000_0000, 1'b0, 1'b1}, // R9
      '{4'd12, 32'hABCD_12FF, 32'h0000_0000, 16'hFF0F, 1'b1, 32'hABCD_12F0, 1'b1, 1'b0}, // R10
      '{4'd12, 32'h1234_5601, 32'h0000_0000, 16'h00FE, 1'b0, 32'h1234_5601, 1'b1, 1'b1}, // R10
      '{4'd13, 32'h0000_0005, 32'h0000_0005, 16'h1234, 1'b1, 32'h0000_0000, 1'b0, 1'b1}, // R11
      '{4'd15, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'hFFFF, 1'b0, 32'h0000_0000, 1'b0, 1'b0}  // R11
   };

   task automatic check(input string tag, input logic ok,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   initial begin : watchdog
      repeat (5000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin : stim
      // R1: reset with activity on the inputs
      in_valid = 1'b1;
      op       = 4'd0;
      src_a    = 32'h1;
      cond_in  = 1'b1;
      repeat (3) @(negedge clk);
      check("R1 reset outputs", !out_valid && !wr_en && result == 0 && !cond_out,
            {out_valid, wr_en, cond_out, result[28:0]}, 32'h0);
      in_valid = 1'b0;
      cond_in  = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // table walk, one operation per cycle, checked one cycle later
      for (int i = 0; i < NV; i++) begin
         in_valid = 1'b1;
         op       = VECS[i].op;
         src_a    = VECS[i].a;
         src_b    = VECS[i].b;
         imm      = VECS[i].imm;
         cond_in  = VECS[i].cin;
         @(negedge clk);
         check($sformatf("vec %0d R2 valid", i), out_valid == 1'b1, {31'b0, out_valid}, 32'h1);
         check($sformatf("vec %0d op %0d result", i, VECS[i].op), result == VECS[i].res,
               result, VECS[i].res);
         check($sformatf("vec %0d op %0d we/cond", i, VECS[i].op),
               wr_en == VECS[i].we && cond_out == VECS[i].c,
               {30'b0, wr_en, cond_out}, {30'b0, VECS[i].we, VECS[i].c});
      end

      // R12: idle cycle, opcode that would write, condition passes through
      in_valid = 1'b0;
      op       = 4'd3;
      src_a    = 32'h7FFF_FFFF;
      src_b    = 32'h1;
      cond_in  = 1'b1;
      @(negedge clk);
      check("R12 idle", !out_valid && !wr_en && cond_out,
            {29'b0, out_valid, wr_en, cond_out}, 32'h1);
      cond_in = 1'b0;
      @(negedge clk);
      check("R12 idle cond follows", !out_valid && !wr_en && !cond_out,
            {29'b0, out_valid, wr_en, cond_out}, 32'h0);

      // R5: carry chain driven by the fed-back condition bit, back to back
      in_valid = 1'b1;
      op       = 4'd5;
      src_a    = 32'hFFFF_FFFF;
      src_b    = 32'hFFFF_FFFF;
      cond_in  = 1'b1;
      @(negedge clk);
      check("R5 all-ones with carry", result == 32'hFFFF_FFFF && cond_out && wr_en,
            result, 32'hFFFF_FFFF);
      cond_in  = cond_out;
      src_a    = 32'h0;
      src_b    = 32'h0;
      @(negedge clk);
      check("R5 carry fed back", result == 32'h1 && !cond_out, result, 32'h1);

      // R1: reset in the middle of a stream
      rst_n = 1'b0;
      @(negedge clk);
      check("R1 mid-stream reset", !out_valid && !wr_en && result == 0 && !cond_out,
            {out_valid, wr_en, cond_out, result[28:0]}, 32'h0);

      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule